// File: doc/BRIEF.md
# Compare and Countdown Timer Channel

This block is one channel of a system timer. It watches an externally supplied, free-running system count and raises a level interrupt when a programmed deadline has been reached. Software can set the deadline in two ways. The first is a 64-bit absolute compare value. The second is a 32-bit signed countdown, which is the distance from the current count to the deadline. Both ways write the same compare register, and the countdown view is always derived from that register and the current count.

The channel can compare against the physical count as it arrives. It can also compare against a virtual count, which is the physical count minus a 64-bit offset register. A small register port with a write strobe and a combinational read gives access to the counts, the compare value, the countdown, the offset and a control word. The control word holds an enable bit, a mask bit, a read-only status bit and the count-select bit.

In the default build, expiry is decided from the 32-bit countdown alone. After the deadline passes, the countdown keeps falling through the negative range. If the count runs more than 2^31 ticks past the deadline without service, the countdown turns positive again and the pending event disappears. A parameter selects a full 64-bit unsigned comparison instead.

Top module: `cmp_timer_channel`

## Requirements
- R1: After reset, the control word reads 0, the compare value and the offset read 0, and `irq_o` is low.
- R2: Reads at byte address 0x00 and 0x04 return the low and high 32 bits of the physical count. Reads at 0x08 and 0x0C return the low and high words of the virtual count, which is the physical count minus the offset. The offset is written at 0x20 (low word) and 0x24 (high word).
- R3: The compare value is written and read at 0x10 (low word) and 0x14 (high word). A write to the countdown address 0x18 sets compare to the selected count plus the sign-extended 32-bit write data.
- R4: A read of 0x18 returns the low 32 bits of compare minus the selected count. After expiry this value keeps decreasing through negative values.
- R5: Control word at 0x1C: bit 0 is enable, bit 1 is mask, bit 2 is status (read-only), bit 3 selects the virtual count when 1. Status reads 1 when enable is set and the countdown is zero or has bit 31 set, whatever the mask. Status reads 0 while enable is clear.
- R6: A countdown write with bit 31 set makes status read 1 at once, with the count unchanged.
- R7: When the count passes the deadline by more than 2^31 ticks, the countdown becomes positive and status returns to 0.
- R8: `irq_o` is registered. It equals enable AND NOT mask AND the fire condition as they stood one clock earlier. Masking removes the interrupt while status stays 1.
- R9: With bit 3 set, both the countdown write and the countdown read use the virtual count.
- R10: Writes to the count addresses and to the status bit have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sys_count_i | input | CNT_W (64) | Free-running system count |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach is the lost event. It needs the count to run 2^31 ticks past a deadline, which a real counter would take many seconds to do. The bench drives the system count as an input, so it can jump the count straight to one tick on either side of that rollover. The same method puts the count next to a 32-bit carry into the compare high word. Virtual-count selection is checked by changing the select bit between a countdown write and the read that follows, so that the offset shows up in the result.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
   localparam int REG_AW = 6;

   typedef enum logic [REG_AW-1:0] {
      A_PCNT_LO = 6'h00,
      A_PCNT_HI = 6'h04,
      A_VCNT_LO = 6'h08,
      A_VCNT_HI = 6'h0C,
      A_CMP_LO  = 6'h10,
      A_CMP_HI  = 6'h14,
      A_CDOWN   = 6'h18,
      A_CTRL    = 6'h1C,
      A_OFS_LO  = 6'h20,
      A_OFS_HI  = 6'h24
   } reg_addr_e;

   localparam int CTL_EN   = 0;
   localparam int CTL_MASK = 1;
   localparam int CTL_STAT = 2;
   localparam int CTL_VSEL = 3;
   localparam int CTL_W    = 4;
endpackage

// File: rtl/tmr_count_view.sv
module tmr_count_view #(
   parameter int CNT_W = 64,
   parameter int TW    = 64
) (
   input  logic [CNT_W-1:0] sys_count_i,
   input  logic [TW-1:0]    offset_i,
   input  logic             vsel_i,
   output logic [TW-1:0]    phys_o,
   output logic [TW-1:0]    virt_o,
   output logic [TW-1:0]    sel_o
);
   localparam int PAD_W = TW - CNT_W;

   generate
      if (CNT_W < 56 || CNT_W > TW) begin : g_bad_width
         $error("tmr_count_view: CNT_W must lie between 56 and TW");
      end
      if (PAD_W == 0) begin : g_full
         assign phys_o = sys_count_i;
      end else begin : g_pad
         assign phys_o = {{PAD_W{1'b0}}, sys_count_i};
      end
   endgenerate

   assign virt_o = phys_o - offset_i;
   assign sel_o  = vsel_i ? virt_o : phys_o;
endmodule

// File: rtl/tmr_deadline.sv
module tmr_deadline #(
   parameter int TW       = 64,
   parameter int DW       = 32,
   parameter bit WIDE_CMP = 1'b0
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [TW-1:0] sel_cnt_i,
   input  logic          wr_lo_i,
   input  logic          wr_hi_i,
   input  logic          wr_cd_i,
   input  logic [DW-1:0] wdata_i,
   output logic [TW-1:0] compare_o,
   output logic [DW-1:0] cdown_o,
   output logic          fire_o
);
   localparam int EXT_W = TW - DW;

   generate
      if (TW != 2 * DW) begin : g_bad_split
         $error("tmr_deadline: compare must be exactly two data words");
      end
   endgenerate

   logic [TW-1:0] cmp_q;
   logic [TW-1:0] delta_ext;

   assign delta_ext = {{EXT_W{wdata_i[DW-1]}}, wdata_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cmp_q <= '0;
      end else if (wr_cd_i) begin
         cmp_q <= sel_cnt_i + delta_ext;
      end else begin
         if (wr_lo_i) cmp_q[DW-1:0]  <= wdata_i;
         if (wr_hi_i) cmp_q[TW-1:DW] <= wdata_i;
      end
   end

   assign compare_o = cmp_q;
   // low bits of a difference depend only on the low bits of its operands
   assign cdown_o   = cmp_q[DW-1:0] - sel_cnt_i[DW-1:0];

   generate
      if (WIDE_CMP) begin : g_wide
         assign fire_o = (sel_cnt_i >= cmp_q);
      end else begin : g_narrow
         assign fire_o = cdown_o[DW-1] | (cdown_o == '0);
      end
   endgenerate
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import cmp_timer_pkg::*;
#(
   parameter int TW = 64,
   parameter int DW = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [REG_AW-1:0] addr_i,
   input  logic [DW-1:0]     wdata_i,
   input  logic [TW-1:0]     phys_i,
   input  logic [TW-1:0]     virt_i,
   input  logic [TW-1:0]     compare_i,
   input  logic [DW-1:0]     cdown_i,
   input  logic              fire_i,
   output logic              en_o,
   output logic              mask_o,
   output logic              vsel_o,
   output logic              status_o,
   output logic [TW-1:0]     offset_o,
   output logic              wr_lo_o,
   output logic              wr_hi_o,
   output logic              wr_cd_o,
   output logic [DW-1:0]     rdata_o
);
   localparam int CTL_PAD = DW - CTL_W;

   logic          en_q, mask_q, vsel_q;
   logic [TW-1:0] ofs_q;

   assign wr_lo_o = we_i && (addr_i == A_CMP_LO);
   assign wr_hi_o = we_i && (addr_i == A_CMP_HI);
   assign wr_cd_o = we_i && (addr_i == A_CDOWN);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q   <= 1'b0;
         mask_q <= 1'b0;
         vsel_q <= 1'b0;
         ofs_q  <= '0;
      end else if (we_i) begin
         if (addr_i == A_CTRL) begin
            en_q   <= wdata_i[CTL_EN];
            mask_q <= wdata_i[CTL_MASK];
            vsel_q <= wdata_i[CTL_VSEL];
         end
         if (addr_i == A_OFS_LO) ofs_q[DW-1:0]  <= wdata_i;
         if (addr_i == A_OFS_HI) ofs_q[TW-1:DW] <= wdata_i;
      end
   end

   assign en_o     = en_q;
   assign mask_o   = mask_q;
   assign vsel_o   = vsel_q;
   assign offset_o = ofs_q;
   assign status_o = en_q & fire_i;

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         A_PCNT_LO: rdata_o = phys_i[DW-1:0];
         A_PCNT_HI: rdata_o = phys_i[TW-1:DW];
         A_VCNT_LO: rdata_o = virt_i[DW-1:0];
         A_VCNT_HI: rdata_o = virt_i[TW-1:DW];
         A_CMP_LO:  rdata_o = compare_i[DW-1:0];
         A_CMP_HI:  rdata_o = compare_i[TW-1:DW];
         A_CDOWN:   rdata_o = cdown_i;
         A_CTRL:    rdata_o = {{CTL_PAD{1'b0}}, vsel_q, status_o, mask_q, en_q};
         A_OFS_LO:  rdata_o = ofs_q[DW-1:0];
         A_OFS_HI:  rdata_o = ofs_q[TW-1:DW];
         default:   rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel
   import cmp_timer_pkg::*;
#(
   parameter int CNT_W    = 64,
   parameter int DW       = 32,
   parameter bit WIDE_CMP = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CNT_W-1:0]  sys_count_i,
   input  logic              reg_we_i,
   input  logic [REG_AW-1:0] reg_addr_i,
   input  logic [DW-1:0]     reg_wdata_i,
   output logic [DW-1:0]     reg_rdata_o,
   output logic              irq_o
);
   localparam int TW = 2 * DW;

   logic [TW-1:0] phys, virt, sel_cnt, compare, offset;
   logic [DW-1:0] cdown;
   logic          fire, en, mask, vsel, status;
   logic          wr_lo, wr_hi, wr_cd;
   logic          irq_q;

   tmr_count_view #(.CNT_W(CNT_W), .TW(TW)) u_view (
      .sys_count_i (sys_count_i),
      .offset_i    (offset),
      .vsel_i      (vsel),
      .phys_o      (phys),
      .virt_o      (virt),
      .sel_o       (sel_cnt)
   );

   tmr_deadline #(.TW(TW), .DW(DW), .WIDE_CMP(WIDE_CMP)) u_deadline (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_cnt_i (sel_cnt),
      .wr_lo_i   (wr_lo),
      .wr_hi_i   (wr_hi),
      .wr_cd_i   (wr_cd),
      .wdata_i   (reg_wdata_i),
      .compare_o (compare),
      .cdown_o   (cdown),
      .fire_o    (fire)
   );

   tmr_regs #(.TW(TW), .DW(DW)) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (reg_we_i),
      .addr_i    (reg_addr_i),
      .wdata_i   (reg_wdata_i),
      .phys_i    (phys),
      .virt_i    (virt),
      .compare_i (compare),
      .cdown_i   (cdown),
      .fire_i    (fire),
      .en_o      (en),
      .mask_o    (mask),
      .vsel_o    (vsel),
      .status_o  (status),
      .offset_o  (offset),
      .wr_lo_o   (wr_lo),
      .wr_hi_o   (wr_hi),
      .wr_cd_o   (wr_cd),
      .rdata_o   (reg_rdata_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= en & ~mask & fire;
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
   import cmp_timer_pkg::*;
#(
   parameter int TW = 64,
   parameter int DW = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              we,
   input logic [REG_AW-1:0] addr,
   input logic [DW-1:0]     wdata,
   input logic [TW-1:0]     sel_cnt,
   input logic [TW-1:0]     compare,
   input logic              fire,
   input logic              en,
   input logic              mask,
   input logic              status,
   input logic              irq
);
   localparam int EXT_W = TW - DW;

   // R8
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(en));

   // R8
   mask_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mask) |-> !irq);

   // R5
   status_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !status);

   // R3
   countdown_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(we && addr == A_CDOWN) |->
         compare == $past(sel_cnt + {{EXT_W{wdata[DW-1]}}, wdata}));

   // R6
   negative_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(we && addr == A_CDOWN && wdata[DW-1]) && sel_cnt == $past(sel_cnt))
         |-> fire);
endmodule

bind cmp_timer_channel tmr_channel_chk #(.TW(TW), .DW(DW)) u_chk (
   .clk     (clk_i),
   .rst_n   (rst_ni),
   .we      (reg_we_i),
   .addr    (reg_addr_i),
   .wdata   (reg_wdata_i),
   .sel_cnt (sel_cnt),
   .compare (compare),
   .fire    (fire),
   .en      (en),
   .mask    (mask),
   .status  (status),
   .irq     (irq_o)
);

// File: tb/test_cmp_timer_channel.sv
`timescale 1ns/1ps
module test_cmp_timer_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] cnt = '0;
   logic        we = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   cmp_timer_channel i_cmp_timer_channel (
      .clk_i(clk), .rst_ni(rst_n), .sys_count_i(cnt), .reg_we_i(we),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
   );

   // rows: start count, countdown written, count at read-back
   localparam logic [159:0] VEC [8] = '{
      {64'd1000, 32'd100, 64'd1000},
      {64'd1000, 32'd100, 64'd1100},
      {64'd1000, 32'd100, 64'd1150},
      {64'd5, 32'h8000_0000, 64'd5},
      {64'h00FF_FFFF_FFFF_0000, 32'h7FFF_FFFF, 64'h00FF_FFFF_FFFF_0000},
      {64'd0, 32'd10, 64'h0000_0000_8000_000A},
      {64'd0, 32'd10, 64'h0000_0000_8000_000B},
      {64'h0000_0000_FFFF_FFF0, 32'h20, 64'h0000_0000_FFFF_FFF0}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [63:0] e;
      logic [31:0] cd;
      string tag;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      cnt = 64'd77;
      rd(6'h1C, d); chk("R1 ctrl", d, 0);
      rd(6'h10, d); chk("R1 cmp lo", d, 0);
      rd(6'h14, d); chk("R1 cmp hi", d, 0);
      rd(6'h20, d); chk("R1 ofs lo", d, 0);
      chk("R1 irq", irq, 0);

      // vector table: enable, masked, physical count
      for (int i = 0; i < 8; i++) begin
         logic [63:0] c0, c1;
         logic [31:0] w;
         {c0, w, c1} = VEC[i];
         wr(6'h1C, 32'h3);
         @(negedge clk); cnt = c0;
         wr(6'h18, w);
         @(negedge clk); cnt = c1;
         e  = c0 + {{32{w[31]}}, w} - c1;
         cd = e[31:0];
         tag = (i == 3) ? "R6" : (i == 6) ? "R7" : "R5";
         rd(6'h18, d); chk($sformatf("R4 row %0d countdown", i), d, cd);
         rd(6'h1C, d); chk($sformatf("%s row %0d status", tag, i), d[2], cd[31] | (cd == 0));
      end
      // R3 carry into compare high word after countdown write
      rd(6'h14, d); chk("R3 compare carry hi", d, 32'h1);
      rd(6'h10, d); chk("R3 compare carry lo", d, 32'h10);

      // R2 counters and offset
      @(negedge clk); cnt = 64'h0000_0123_4567_89AB;
      wr(6'h20, 32'h10);
      wr(6'h24, 32'h1);
      rd(6'h00, d); chk("R2 phys lo", d, 32'h4567_89AB);
      rd(6'h04, d); chk("R2 phys hi", d, 32'h0000_0123);
      rd(6'h08, d); chk("R2 virt lo", d, 32'h4567_899B);
      rd(6'h0C, d); chk("R2 virt hi", d, 32'h0000_0122);

      // R10 writes to counts do not change them
      wr(6'h00, 32'hDEAD_BEEF);
      wr(6'h0C, 32'hDEAD_BEEF);
      rd(6'h00, d); chk("R10 phys untouched", d, 32'h4567_89AB);
      rd(6'h0C, d); chk("R10 virt untouched", d, 32'h0000_0122);

      // R9 virtual select
      wr(6'h1C, 32'hB);            // vsel, mask, en
      wr(6'h18, 32'd100);
      rd(6'h10, d); chk("R9 compare from virt", d, 32'h4567_89FF);
      rd(6'h18, d); chk("R9 countdown virt", d, 32'd100);
      wr(6'h1C, 32'h3);
      rd(6'h18, d); chk("R9 countdown phys", d, 32'd84);

      // R3 direct compare write and read-back
      wr(6'h10, 32'h4567_8A00);
      wr(6'h14, 32'h0000_0123);
      rd(6'h14, d); chk("R3 cmp hi", d, 32'h0000_0123);
      rd(6'h18, d); chk("R3 countdown after abs write", d, 32'h55);

      // R10 status bit not writable (deadline in future)
      wr(6'h1C, 32'h7);
      rd(6'h1C, d); chk("R10 status ro", d, 32'h3);

      // R8 interrupt timing and masking
      wr(6'h1C, 32'h1);
      chk("R8 irq low before expiry", irq, 0);
      wr(6'h18, 32'd0);
      chk("R8 irq still low one cycle", irq, 0);
      @(negedge clk);
      chk("R8 irq high", irq, 1);
      wr(6'h1C, 32'h3);
      @(negedge clk);
      chk("R8 irq masked", irq, 0);
      rd(6'h1C, d); chk("R8 status while masked", d[2], 1);

      // R5 disable clears status and irq
      wr(6'h1C, 32'h0);
      @(negedge clk);
      rd(6'h1C, d); chk("R5 status disabled", d[2], 0);
      chk("R5 irq disabled", irq, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule